// File: doc/BRIEF.md
# Edge-Capture Status and Interrupt Register

This block collects event flags into a single status word and drives one active-high interrupt line. It watches four general-purpose pins. Each pin has its own sticky rising-edge flag and its own sticky falling-edge flag. There are two more flags. A day-alarm flag sets when a programmed 20-bit seconds value equals the running seconds count. A conversion-ready flag sets on a one-cycle pulse from a converter.

Every pin passes through a two-flop synchronizer before edge detection. The block samples the pad value, so a transition is recorded whether the pin is being driven by the chip or by the outside world. No direction input is needed. Software reads the status word on `rd_data_o`. It pulses `rd_stb_i` to clear all flags. The interrupt line is raised whenever a set flag has its mask bit set.

Status word layout, `NUM_PINS` = 4:

| Bit(s) | Flag |
|---|---|
| 0 | conversion ready |
| 1 | day alarm |
| 2..5 | rising edge on pins 0..3 |
| 6..9 | falling edge on pins 0..3 |

The mask word uses the same layout.

Top module: `evt_status_irq`

## Requirements
- R1: After reset, every status bit is 0, `irq_o` is 0 and the mask is 10'b00_0000_0001. That mask leaves only the conversion-ready bit (bit 0) unmasked.
- R2: A 0-to-1 change on `pin_i[i]` sets status bit 2+i. The bit is visible on the third rising clock edge after the change. It then holds until a read, and no flag is set while the pins are stable.
- R3: A 1-to-0 change on `pin_i[i]` sets status bit 2+NUM_PINS+i (bit 6+i) with the same timing and stickiness as R2.
- R4: A clock edge with `rd_stb_i` high clears every status bit that has no new event in that same cycle.
- R5: An event that arrives in the same cycle as a clearing read leaves its flag set after that edge.
- R6: Status bit 1 sets on the first cycle in which `sec_cnt_i` equals `alm_sec_i` while `alm_en_i` is high. A match seen while `alm_en_i` is low sets nothing, and enabling during an ongoing match also sets nothing.
- R7: While `alm_en_i` is low, status bit 1 is cleared on the next clock edge.
- R8: A one-cycle pulse on `cvt_rdy_i` sets status bit 0 on that clock edge.
- R9: `irq_o` is high exactly when some status bit and its mask bit are both 1. A mask written with `mask_we_i` takes effect from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Pad values of the monitored pins |
| cvt_rdy_i | input | 1 | Conversion-ready event pulse |
| sec_cnt_i | input | SEC_W | Running seconds count |
| alm_sec_i | input | SEC_W | Programmed alarm seconds value |
| alm_en_i | input | 1 | Day-alarm enable |
| rd_stb_i | input | 1 | Status read strobe; clears the flags |
| rd_data_o | output | 2+2*NUM_PINS | Current status word |
| mask_we_i | input | 1 | Mask write enable |
| mask_wdata_i | input | 2+2*NUM_PINS | Mask write data |
| irq_o | output | 1 | Active-high interrupt |

## Verification
Every internal fault shows up on the ports within a few clock edges, because the status word is visible on `rd_data_o` at all times:

- A stuck or missed synchronizer stage moves an edge flag off its third-edge slot, or drops it entirely.
- A swapped rise/fall decode lights the wrong half of the word.
- A wrong clear priority loses an event that coincides with a read, and the next sample shows it.
- A faulty alarm one-shot either misses the match or re-arms after a read during a held match.
- A mask fault shows on `irq_o` one edge after the mask write.

// File: rtl/evt_pkg.sv
package evt_pkg;
  // Fixed positions of the non-pin flags in the status and mask words
  localparam int unsigned CVT_BIT  = 0;
  localparam int unsigned ALM_BIT  = 1;
  localparam int unsigned PIN_BASE = 2;

  // Width of the status word for a given pin count
  function automatic int unsigned stat_width(input int unsigned pins);
    return PIN_BASE + 2 * pins;
  endfunction

  // Index of the rising-edge flag of pin p
  function automatic int unsigned rise_idx(input int unsigned p);
    return PIN_BASE + p;
  endfunction

  // Index of the falling-edge flag of pin p
  function automatic int unsigned fall_idx(input int unsigned pins, input int unsigned p);
    return PIN_BASE + pins + p;
  endfunction
endpackage

// File: rtl/evt_pin_edge.sv
module evt_pin_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;

  // R2
  rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> $past(meta_q));
  // R3
  fall_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> !$past(meta_q));
endmodule

// File: rtl/evt_alarm_match.sv
module evt_alarm_match #(
  parameter int unsigned SEC_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEC_W-1:0] sec_cnt_i,
  input  logic [SEC_W-1:0] alm_sec_i,
  input  logic             alm_en_i,
  output logic             hit_o
);
  logic match, match_q;

  function automatic logic sec_equal(input logic [SEC_W-1:0] a, input logic [SEC_W-1:0] b);
    return (a == b);
  endfunction

  assign match = sec_equal(sec_cnt_i, alm_sec_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= match;
  end

  // One pulse on the first cycle of a match, only while enabled
  assign hit_o = alm_en_i & match & ~match_q;

  // R6
  hit_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o);
  // R6
  hit_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alm_en_i |-> !hit_o);
endmodule

// File: rtl/evt_status_irq.sv
module evt_status_irq #(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned SEC_W    = 20
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_PINS-1:0]        pin_i,
  input  logic                       cvt_rdy_i,
  input  logic [SEC_W-1:0]           sec_cnt_i,
  input  logic [SEC_W-1:0]           alm_sec_i,
  input  logic                       alm_en_i,
  input  logic                       rd_stb_i,
  output logic [2+2*NUM_PINS-1:0]    rd_data_o,
  input  logic                       mask_we_i,
  input  logic [2+2*NUM_PINS-1:0]    mask_wdata_i,
  output logic                       irq_o
);
  import evt_pkg::*;

  localparam int unsigned STAT_W = stat_width(NUM_PINS);
  localparam logic [STAT_W-1:0] MASK_RST = STAT_W'(1) << CVT_BIT;

  logic [NUM_PINS-1:0] rise_w, fall_w;
  logic                alm_hit_w;
  logic [STAT_W-1:0]   set_vec, keep_vec, stat_q, stat_d, mask_q;

  function automatic logic irq_of(input logic [STAT_W-1:0] s, input logic [STAT_W-1:0] m);
    return |(s & m);
  endfunction

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    evt_pin_edge u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pin_i[p]),
      .rise_o (rise_w[p]),
      .fall_o (fall_w[p])
    );
  end

  evt_alarm_match #(.SEC_W(SEC_W)) u_alarm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sec_cnt_i (sec_cnt_i),
    .alm_sec_i (alm_sec_i),
    .alm_en_i  (alm_en_i),
    .hit_o     (alm_hit_w)
  );

  // New events this cycle
  always_comb begin
    set_vec = '0;
    set_vec[CVT_BIT] = cvt_rdy_i;
    set_vec[ALM_BIT] = alm_hit_w;
    for (int p = 0; p < NUM_PINS; p++) begin
      set_vec[rise_idx(p)]           = rise_w[p];
      set_vec[fall_idx(NUM_PINS, p)] = fall_w[p];
    end
  end

  // Flags surviving this cycle: all cleared by a read, alarm also by disable
  always_comb begin
    keep_vec = rd_stb_i ? '0 : stat_q;
    if (!alm_en_i) keep_vec[ALM_BIT] = 1'b0;
    stat_d = keep_vec | set_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= MASK_RST;
    end else begin
      stat_q <= stat_d;
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign rd_data_o = stat_q;
  assign irq_o     = irq_of(stat_q, mask_q);

  // R4
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && set_vec == '0) |=> (stat_q == '0));
  // R5
  event_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(set_vec) & ~stat_q) == '0));
  // R2
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_stb_i && alm_en_i) |=> (($past(stat_q) & ~stat_q) == '0));
  // R7
  alm_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alm_en_i |=> !stat_q[ALM_BIT]);
  // R9
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);
endmodule

// File: tb/evt_status_irq_bench.sv
module evt_status_irq_bench;
  localparam int N = 4;
  localparam int W = 2 + 2 * N;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] pins = '0;
  logic cvt = 0, alm_en = 0, rd = 0, mwe = 0;
  logic [19:0] sec = '0, alm = '0;
  logic [W-1:0] mwd = '0, rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  evt_status_irq u_evt_status_irq (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .cvt_rdy_i(cvt),
    .sec_cnt_i(sec), .alm_sec_i(alm), .alm_en_i(alm_en), .rd_stb_i(rd),
    .rd_data_o(rdata), .mask_we_i(mwe), .mask_wdata_i(mwd), .irq_o(irq)
  );

  // {pins to apply, expected rise field, expected fall field}
  localparam logic [11:0] VEC [6] = '{
    {4'b0101, 4'b0101, 4'b0000},
    {4'b0011, 4'b0010, 4'b0100},
    {4'b1100, 4'b1100, 4'b0011},
    {4'b1100, 4'b0000, 4'b0000},
    {4'b0000, 4'b0000, 4'b1100},
    {4'b1111, 4'b1111, 4'b0000}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    rd = 1; step(1); rd = 0;
  endtask

  initial begin
    step(2);
    // R1 reset state
    check(rdata == '0, "R1 status", rdata, 0);
    check(irq == 0, "R1 irq", irq, 0);
    rst_n = 1; step(1);
    check(rdata == '0 && irq == 0, "R1 after release", rdata, 0);

    // R2 / R3 vector walk
    foreach (VEC[i]) begin
      pins = VEC[i][11:8];
      step(2);
      check(rdata == '0, "R2 not before third edge", rdata, 0);
      step(1);
      check(rdata[5:2] == VEC[i][7:4], "R2 rise field", rdata[5:2], VEC[i][7:4]);
      check(rdata[9:6] == VEC[i][3:0], "R3 fall field", rdata[9:6], VEC[i][3:0]);
      step(3);
      check(rdata[9:2] == {VEC[i][3:0], VEC[i][7:4]}, "R2 sticky", rdata, {VEC[i][3:0], VEC[i][7:4]});
      check(irq == 0, "R9 pin flags masked", irq, 0);
      do_read();
      check(rdata == '0, "R4 read clears", rdata, 0);
    end

    // R8 conversion ready, unmasked at reset
    cvt = 1; step(1); cvt = 0;
    check(rdata == 10'h001, "R8 cvt flag", rdata, 1);
    check(irq == 1, "R1/R9 cvt unmasked", irq, 1);
    do_read();
    check(rdata == '0 && irq == 0, "R4 cvt cleared", rdata, 0);

    // R5 event coinciding with read
    cvt = 1; step(1); cvt = 0;
    cvt = 1; rd = 1; step(1); cvt = 0; rd = 0;
    check(rdata == 10'h001, "R5 kept on read", rdata, 1);
    do_read();

    // R6 alarm disabled: match sets nothing
    alm = 20'd7; sec = 20'd7; step(2);
    check(rdata[1] == 0, "R6 disabled no set", rdata[1], 0);
    alm_en = 1; step(2);
    check(rdata[1] == 0, "R6 enable mid-match no set", rdata[1], 0);
    sec = 20'd8; step(1);
    alm = 20'hABCDE; sec = 20'hABCDD; step(1);
    check(rdata[1] == 0, "R6 no set before match", rdata[1], 0);
    sec = 20'hABCDE; step(1);
    check(rdata[1] == 1, "R6 alarm set", rdata[1], 1);
    check(irq == 0, "R9 alarm masked", irq, 0);
    mwd = 10'h002; mwe = 1; step(1); mwe = 0;
    check(irq == 1, "R9 mask write", irq, 1);
    do_read();
    step(2);
    check(rdata[1] == 0, "R6 held match no re-set", rdata[1], 0);

    // R7 disable clears alarm bit
    sec = 20'd0; step(1); sec = 20'hABCDE; step(1);
    check(rdata[1] == 1, "R6 second match", rdata[1], 1);
    alm_en = 0; step(1);
    check(rdata[1] == 0 && irq == 0, "R7 disable clears", rdata, 0);

    // R9 per-pin mask gating
    mwd = 10'h040; mwe = 1; step(1); mwe = 0;
    pins = 4'b1110; step(4);
    check(rdata == 10'h040 && irq == 1, "R9 fall pin0 unmasked", {irq, rdata}, 11'h440);
    do_read();
    pins = 4'b1111; step(4);
    check(rdata == 10'h004 && irq == 0, "R9 rise pin0 masked", {irq, rdata}, 11'h004);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule